// File: doc/BRIEF.md
# Branch Condition Evaluator

This unit decides whether a conditional branch is taken. Each cycle it can accept five status flags and a 4-bit condition selector. The flags are carry, zero, sign, overflow and parity. One clock edge later it presents a single taken bit together with a valid strobe. The strobe follows the input valid, so the unit lines up with a flag source that sits one pipeline stage earlier.

Bits 3 to 1 of the selector pick one of eight base predicates. These cover a single flag, an unsigned relation built from carry and zero, and a signed relation built from sign against overflow. Bit 0 of the selector complements the chosen predicate. Each even code and the odd code above it therefore form a negation pair. When no request is presented, the output bit keeps its last value.

Top module: `branch_cond_eval`

## Requirements
- R1: During and straight after reset, `res_valid` and `res_taken` are 0.
- R2: `res_valid` equals the value `req_valid` had at the previous rising clock edge. `res_taken` belongs to the request sampled at that edge.
- R3: Code 0 is taken when overflow is 1. Code 1 is taken when overflow is 0.
- R4: Code 2 (unsigned below) is taken when carry is 1. Code 3 (unsigned above-or-equal) is taken when carry is 0.
- R5: Code 4 (equal) is taken when zero is 1. Code 5 (not equal) is taken when zero is 0.
- R6: Code 6 (unsigned below-or-equal) is taken when carry or zero is 1. Code 7 (unsigned above) is taken only when carry and zero are both 0.
- R7: Code 8 is taken when sign is 1. Code 9 is taken when sign is 0.
- R8: Code 10 is taken when the parity flag is 1 (even parity). Code 11 is taken when the parity flag is 0.
- R9: Code 12 (signed less) is taken when sign differs from overflow. Code 13 (signed greater-or-equal) is taken when they match.
- R10: Code 14 (signed less-or-equal) is taken when zero is 1 or sign differs from overflow. Code 15 (signed greater) is taken when zero is 0 and sign equals overflow.
- R11: For any flag set, the odd code 2k+1 gives the complement of the even code 2k.
- R12: A cycle with `req_valid` at 0 is ignored. In the next cycle `res_valid` is 0 and `res_taken` keeps its earlier value, whatever the flags and code were.
- R13: After comparing 0x80 with 0x7F at 8 bits (flags from 0x80 − 0x7F), code 12 is taken and code 2 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Flags and code are presented this cycle |
| st_carry | input | 1 | Carry (borrow) flag |
| st_zero | input | 1 | Zero flag |
| st_sign | input | 1 | Sign flag |
| st_ovf | input | 1 | Signed overflow flag |
| st_parity | input | 1 | Parity flag, 1 for even parity |
| cond_sel | input | 4 | Condition code 0 to 15 |
| res_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| res_taken | output | 1 | Branch taken |

## Verification
The main sweep drives all 32 flag combinations under each of the 16 codes. Because every flag is toggled against every predicate, a predicate that reads the wrong flag or builds its signed relation from the wrong pair is caught. A separate pass compares each odd code with its even partner, so a wrong inversion bit shows up even where both codes happen to agree with a wrong base.

The compare of 0x80 with 0x7F produces flags where the signed and unsigned views disagree. A design that swaps the signed and unsigned families fails this case. Idle cycles with changing inputs show whether the unit ignores requests that are not marked valid.

// File: rtl/bcond_pkg.sv
package bcond_pkg;

  localparam int unsigned COND_W   = 4;
  localparam int unsigned BASE_W   = COND_W - 1;
  localparam int unsigned NUM_BASE = 1 << BASE_W;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } status_t;

  // Base predicate index = cond_sel[3:1]
  typedef enum logic [BASE_W-1:0] {
    BP_OVF   = 3'd0,
    BP_BELOW = 3'd1,
    BP_EQ    = 3'd2,
    BP_BE    = 3'd3,
    BP_SIGN  = 3'd4,
    BP_PEVEN = 3'd5,
    BP_LT    = 3'd6,
    BP_LE    = 3'd7
  } base_pred_e;

  function automatic logic signed_lt(input status_t s);
    return s.sf ^ s.of;
  endfunction

  function automatic logic signed_le(input status_t s);
    return s.zf | signed_lt(s);
  endfunction

  function automatic logic unsigned_be(input status_t s);
    return s.cf | s.zf;
  endfunction

endpackage

// File: rtl/bcond_relations.sv
module bcond_relations
  import bcond_pkg::*;
(
  input  status_t               st,
  output logic [NUM_BASE-1:0]   base_pred
);

  always_comb begin
    base_pred           = '0;
    base_pred[BP_OVF]   = st.of;
    base_pred[BP_BELOW] = st.cf;
    base_pred[BP_EQ]    = st.zf;
    base_pred[BP_BE]    = unsigned_be(st);
    base_pred[BP_SIGN]  = st.sf;
    base_pred[BP_PEVEN] = st.pf;
    base_pred[BP_LT]    = signed_lt(st);
    base_pred[BP_LE]    = signed_le(st);
  end

endmodule

// File: rtl/bcond_select.sv
module bcond_select
  import bcond_pkg::*;
(
  input  logic [NUM_BASE-1:0] base_pred,
  input  logic [COND_W-1:0]   cond_sel,
  output logic                pred_base,
  output logic                taken
);

  logic [BASE_W-1:0] base_idx;
  logic              invert;

  assign base_idx = cond_sel[COND_W-1:1];
  assign invert   = cond_sel[0];

  always_comb begin
    pred_base = 1'b0;
    for (int i = 0; i < NUM_BASE; i++) begin
      if (base_idx == BASE_W'(i)) pred_base = base_pred[i];
    end
  end

  assign taken = pred_base ^ invert;

endmodule

// File: rtl/bcond_stage.sv
module bcond_stage #(
  parameter int unsigned DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bcond_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        st_carry,
  input  logic        st_zero,
  input  logic        st_sign,
  input  logic        st_ovf,
  input  logic        st_parity,
  input  logic [3:0]  cond_sel,
  output logic        res_valid,
  output logic        res_taken
);

  status_t             st;
  logic [NUM_BASE-1:0] base_pred;
  logic                pred_base;
  logic                taken_comb;

  assign st = '{cf: st_carry, zf: st_zero, sf: st_sign, of: st_ovf, pf: st_parity};

  bcond_relations u_rel (
    .st        (st),
    .base_pred (base_pred)
  );

  bcond_select u_sel (
    .base_pred (base_pred),
    .cond_sel  (cond_sel),
    .pred_base (pred_base),
    .taken     (taken_comb)
  );

  bcond_stage #(.DATA_W(1)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_data   (taken_comb),
    .out_valid (res_valid),
    .out_data  (res_taken)
  );

  // R1: outputs cleared while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (res_valid == 1'b0 && res_taken == 1'b0);
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_idle_no_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_taken));

  assert_below_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_sel == 4'd2) |=> (res_taken == $past(st_carry)));

  assert_equal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_sel == 4'd5) |=> (res_taken == !$past(st_zero)));

  assert_signed_less_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_sel == 4'd12) |=> (res_taken == ($past(st_sign) != $past(st_ovf))));

  assert_signed_greater_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_sel == 4'd15) |=>
      (res_taken == (!$past(st_zero) && ($past(st_sign) == $past(st_ovf)))));

endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       st_carry = 1'b0, st_zero = 1'b0, st_sign = 1'b0, st_ovf = 1'b0, st_parity = 1'b0;
  logic [3:0] cond_sel = 4'd0;
  logic       res_valid, res_taken;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  branch_cond_eval i_branch_cond_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .st_carry  (st_carry),
    .st_zero   (st_zero),
    .st_sign   (st_sign),
    .st_ovf    (st_ovf),
    .st_parity (st_parity),
    .cond_sel  (cond_sel),
    .res_valid (res_valid),
    .res_taken (res_taken)
  );

  // flags packed as {carry, zero, sign, ovf, parity}
  function automatic logic expect_taken(input logic [3:0] code, input logic [4:0] f);
    logic c, z, s, o, p;
    {c, z, s, o, p} = f;
    case (code)
      4'd0:  return o;
      4'd1:  return !o;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return z;
      4'd5:  return !z;
      4'd6:  return c || z;
      4'd7:  return !c && !z;
      4'd8:  return s;
      4'd9:  return !s;
      4'd10: return p;
      4'd11: return !p;
      4'd12: return s != o;
      4'd13: return s == o;
      4'd14: return z || (s != o);
      default: return !z && (s == o);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    case (code[3:1])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic v, input logic [4:0] f, input logic [3:0] code);
    @(negedge clk);
    req_valid = v;
    {st_carry, st_zero, st_sign, st_ovf, st_parity} = f;
    cond_sel = code;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset;
    check("R1", "res_valid in reset", res_valid, 1'b0);
    check("R1", "res_taken in reset", res_taken, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "res_valid after reset", res_valid, 1'b0);
    check("R1", "res_taken after reset", res_taken, 1'b0);
  endtask

  task automatic test_full_sweep;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        step(1'b1, 5'(f), 4'(c));
        check("R2", "res_valid after request", res_valid, 1'b1);
        check(req_of(4'(c)), $sformatf("code %0d flags %05b", c, f),
              res_taken, expect_taken(4'(c), 5'(f)));
      end
    end
  endtask

  task automatic test_pairs_R11;
    logic even_r;
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 32; f++) begin
        step(1'b1, 5'(f), 4'(2 * k));
        even_r = res_taken;
        step(1'b1, 5'(f), 4'(2 * k + 1));
        check("R11", $sformatf("pair %0d flags %05b", k, f), res_taken, !even_r);
      end
    end
  endtask

  task automatic test_idle_R12;
    logic held;
    step(1'b1, 5'b00000, 4'd3);  // carry 0 -> taken 1
    held = res_taken;
    check("R12", "setup taken", held, 1'b1);
    step(1'b0, 5'b10000, 4'd3);  // would give 0 if accepted
    check("R12", "idle res_valid", res_valid, 1'b0);
    check("R12", "idle res_taken hold", res_taken, held);
    step(1'b0, 5'b11111, 4'd7);
    check("R12", "idle res_taken hold 2", res_taken, held);
    step(1'b1, 5'b10000, 4'd3);
    check("R2", "valid returns", res_valid, 1'b1);
    check("R2", "new request result", res_taken, 1'b0);
  endtask

  task automatic test_compare_R13;
    logic [8:0] diff;
    logic [4:0] f;
    logic [7:0] a, b;
    a = 8'h80;
    b = 8'h7F;
    diff = {1'b0, a} - {1'b0, b};
    f[4] = diff[8];
    f[3] = (diff[7:0] == 8'h00);
    f[2] = diff[7];
    f[1] = (a[7] != b[7]) && (diff[7] != a[7]);
    f[0] = ~^diff[7:0];
    step(1'b1, f, 4'd12);
    check("R13", "0x80 vs 0x7F signed less", res_taken, 1'b1);
    step(1'b1, f, 4'd2);
    check("R13", "0x80 vs 0x7F unsigned below", res_taken, 1'b0);
  endtask

  logic done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    test_reset();
    test_full_sweep();
    test_pairs_R11();
    test_idle_R12();
    test_compare_R13();
    step(1'b0, 5'b00000, 4'd0);
    check("R2", "no request, no valid", res_valid, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule